// File: doc/BRIEF.md
# Skewed Bank Write-Priority Arbiter

The block stands in front of a row of folded, skewed data SRAM banks that several cache ways share. A bank is addressed by a column and a bank select. Every way offers a fixed number of request parts each cycle. A part carries a valid bit, a write flag, a target column, a target bank select, a bank address and write data. For each (column, bank-select) slot, the arbiter picks at most one part to drive the bank's enable, write flag, address and write data. Writes always take priority over reads.

The arbiter also returns a grant for every part. Write parts are always granted. A read part is granted only when it won the read selection for its slot and no part of a different way writes that slot in the same cycle. A write from the reader's own way never withholds the read grant. Because of this rule, a requester whose read lost to a foreign write stalls and retries, and it never consumes stale read data. When a read drives a bank, the bank's read word comes back one cycle later through a registered response valid, tagged with the index of the winning way.

Each slot is classified every cycle into one of three states: IDLE when no part targets it, READ when only read parts target it, and WRITE when at least one write part targets it. The classification is purely combinational and is recomputed each cycle. WRITE takes precedence over READ, and READ takes precedence over IDLE.

Top module: `skew_bank_arb`

## Requirements
- R1: Each slot's bank is enabled only when at least one valid part targets that slot, and the driving part is one of the parts that target it.
- R2: When write and read parts target the same slot, the bank sees a write (bank_we=1) carrying the selected writer's address and data.
- R3: Every valid write part receives req_gnt=1 in the same cycle, whatever else targets its slot.
- R4: A valid read part receives req_gnt=0 whenever a valid write part of a different way targets the same slot in the same cycle.
- R5: A write from the reader's own way to the same slot does not by itself withhold the read grant.
- R6: Among several write parts on one slot, the part with the lowest index drives the bank. The part index is way*PARTS_PER_WAY+part, so lower ways win.
- R7: Among read parts on one slot, only the lowest-indexed reader can be granted. With no write present, that reader drives the bank address with bank_we=0.
- R8: One clock after a slot is driven as a read, rsp_vld for that slot is 1, rsp_way holds the winning part's way, and rsp_data carries that slot's bank read word. Otherwise rsp_vld is 0, and it is 0 throughout reset.
- R9: A part addresses slot index col*NUM_BANKS+bank, and a slot that no valid part targets has bank_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | NP | Part valid, one bit per part (NP = NUM_WAYS*PARTS_PER_WAY) |
| req_we | input | NP | Part is a write |
| req_col | input | NP*COL_W | Target column per part |
| req_bank | input | NP*BSEL_W | Target bank select per part |
| req_addr | input | NP*ADDR_W | Bank word address per part |
| req_wdata | input | NP*DATA_W | Write data per part |
| req_gnt | output | NP | Grant per part |
| bank_en | output | NS | Bank enable per slot (NS = NUM_COLS*NUM_BANKS) |
| bank_we | output | NS | Bank write enable per slot |
| bank_addr | output | NS*ADDR_W | Bank address per slot |
| bank_wdata | output | NS*DATA_W | Bank write data per slot |
| bank_rdata | input | NS*DATA_W | Read word from each bank, valid one cycle after a read |
| rsp_vld | output | NS | Read response valid per slot |
| rsp_way | output | NS*WAY_W | Winning way of the read being answered |
| rsp_data | output | NS*DATA_W | Read word returned per slot |

## Verification
Grants and all bank-side outputs are combinational, so they are due in the same cycle the parts are presented. The bench checks them shortly after driving inputs on the falling edge, well before the next rising edge. Read responses are due exactly one rising edge later. At check time, the driver queues each expected response tagged with the number of the next cycle. A monitor on the following falling edge pops only the entries tagged with the current cycle and compares every slot's rsp_vld, rsp_way and rsp_data. An early, late or missing response therefore shows up as a mismatch.

// File: rtl/sba_pkg.sv
package sba_pkg;

    // Per-slot classification for one cycle.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10
    } slot_op_e;

endpackage

// File: rtl/sba_slot_arb.sv
module sba_slot_arb
    import sba_pkg::*;
#(
    parameter int NP     = 8,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    localparam int IDX_W = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic [NP-1:0]        hit_wr,
    input  logic [NP-1:0]        hit_rd,
    input  logic [NP*ADDR_W-1:0] addr_flat,
    input  logic [NP*DATA_W-1:0] wdata_flat,
    output slot_op_e             op,
    output logic [IDX_W-1:0]     sel_idx,
    output logic [ADDR_W-1:0]    addr,
    output logic [DATA_W-1:0]    wdata,
    output logic [NP-1:0]        rd_first
);

    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    // Lowest-indexed candidate of each kind (scan downward, last hit wins).
    always_comb begin : pick
        wr_idx = '0;
        rd_idx = '0;
        for (int i = NP - 1; i >= 0; i--) begin
            if (hit_wr[i]) wr_idx = IDX_W'(i);
            if (hit_rd[i]) rd_idx = IDX_W'(i);
        end
    end

    always_comb begin : classify
        if (|hit_wr)      op = OP_WRITE;
        else if (|hit_rd) op = OP_READ;
        else              op = OP_IDLE;
    end

    always_comb begin : drive
        rd_first = '0;
        unique case (op)
            OP_WRITE: sel_idx = wr_idx;
            OP_READ:  sel_idx = rd_idx;
            default:  sel_idx = '0;
        endcase
        if (|hit_rd) rd_first[rd_idx] = 1'b1;
        addr  = addr_flat[int'(sel_idx)*ADDR_W +: ADDR_W];
        wdata = wdata_flat[int'(sel_idx)*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/sba_grant_gen.sv
module sba_grant_gen #(
    parameter int NP            = 8,
    parameter int PARTS_PER_WAY = 2,
    parameter int SLOT_W        = 3
) (
    input  logic [NP-1:0]        req_vld,
    input  logic [NP-1:0]        req_we,
    input  logic [NP*SLOT_W-1:0] slot_flat,
    input  logic [NP-1:0]        rd_first,
    output logic [NP-1:0]        req_gnt
);

    logic [NP-1:0] foreign_wr;

    // Loop-free: depends only on valid/write flags and slot numbers.
    always_comb begin : conflict
        for (int p = 0; p < NP; p++) begin
            foreign_wr[p] = 1'b0;
            for (int q = 0; q < NP; q++) begin
                if ((q / PARTS_PER_WAY) != (p / PARTS_PER_WAY) && req_vld[q] && req_we[q]
                    && slot_flat[q*SLOT_W +: SLOT_W] == slot_flat[p*SLOT_W +: SLOT_W])
                    foreign_wr[p] = 1'b1;
            end
        end
    end

    always_comb begin : grant
        for (int p = 0; p < NP; p++)
            req_gnt[p] = req_vld[p] && (req_we[p] || (!foreign_wr[p] && rd_first[p]));
    end

endmodule

// File: rtl/sba_rsp_reg.sv
module sba_rsp_reg #(
    parameter int NS    = 8,
    parameter int WAY_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NS-1:0]       rd_fire,
    input  logic [NS*WAY_W-1:0] rd_way_flat,
    output logic [NS-1:0]       rsp_vld,
    output logic [NS*WAY_W-1:0] rsp_way
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld <= '0;
            rsp_way <= '0;
        end else begin
            rsp_vld <= rd_fire;
            rsp_way <= rd_way_flat;
        end
    end

endmodule

// File: rtl/skew_bank_arb.sv
module skew_bank_arb
    import sba_pkg::*;
#(
    parameter int NUM_WAYS      = 4,
    parameter int PARTS_PER_WAY = 2,
    parameter int NUM_COLS      = 4,
    parameter int NUM_BANKS     = 2,
    parameter int ADDR_W        = 6,
    parameter int DATA_W        = 16,
    localparam int NP     = NUM_WAYS * PARTS_PER_WAY,
    localparam int NS     = NUM_COLS * NUM_BANKS,
    localparam int COL_W  = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
    localparam int BSEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int WAY_W  = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NP-1:0]        req_vld,
    input  logic [NP-1:0]        req_we,
    input  logic [NP*COL_W-1:0]  req_col,
    input  logic [NP*BSEL_W-1:0] req_bank,
    input  logic [NP*ADDR_W-1:0] req_addr,
    input  logic [NP*DATA_W-1:0] req_wdata,
    output logic [NP-1:0]        req_gnt,
    output logic [NS-1:0]        bank_en,
    output logic [NS-1:0]        bank_we,
    output logic [NS*ADDR_W-1:0] bank_addr,
    output logic [NS*DATA_W-1:0] bank_wdata,
    input  logic [NS*DATA_W-1:0] bank_rdata,
    output logic [NS-1:0]        rsp_vld,
    output logic [NS*WAY_W-1:0]  rsp_way,
    output logic [NS*DATA_W-1:0] rsp_data
);

    localparam int SLOT_W = (NS > 1) ? $clog2(NS) : 1;
    localparam int IDX_W  = (NP > 1) ? $clog2(NP) : 1;

    logic [NP*SLOT_W-1:0] slot_flat;
    logic [NP-1:0]        hit_wr [NS];
    logic [NP-1:0]        hit_rd [NS];
    logic [NP-1:0]        rd_first [NS];
    logic [NP-1:0]        rd_first_any;
    logic [NP-1:0]        rd_gnt_slot [NS];
    slot_op_e             op [NS];
    logic [IDX_W-1:0]     sel_idx [NS];
    logic [WAY_W-1:0]     sel_way [NS];
    logic [NS-1:0]        rd_fire;
    logic [NS*WAY_W-1:0]  rd_way_flat;

    // Slot index = col * NUM_BANKS + bank.
    always_comb begin : slot_map
        for (int p = 0; p < NP; p++)
            slot_flat[p*SLOT_W +: SLOT_W] = SLOT_W'(int'(req_col[p*COL_W +: COL_W]) * NUM_BANKS
                                                    + int'(req_bank[p*BSEL_W +: BSEL_W]));
    end

    always_comb begin : hit_map
        for (int s = 0; s < NS; s++) begin
            for (int p = 0; p < NP; p++) begin
                hit_wr[s][p] = req_vld[p] && req_we[p]
                               && (int'(slot_flat[p*SLOT_W +: SLOT_W]) == s);
                hit_rd[s][p] = req_vld[p] && !req_we[p]
                               && (int'(slot_flat[p*SLOT_W +: SLOT_W]) == s);
            end
        end
    end

    for (genvar s = 0; s < NS; s++) begin : g_slot
        sba_slot_arb #(.NP(NP), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
            .hit_wr     (hit_wr[s]),
            .hit_rd     (hit_rd[s]),
            .addr_flat  (req_addr),
            .wdata_flat (req_wdata),
            .op         (op[s]),
            .sel_idx    (sel_idx[s]),
            .addr       (bank_addr[s*ADDR_W +: ADDR_W]),
            .wdata      (bank_wdata[s*DATA_W +: DATA_W]),
            .rd_first   (rd_first[s])
        );
        assign bank_en[s] = (op[s] != OP_IDLE);
        assign bank_we[s] = (op[s] == OP_WRITE);
        assign rd_fire[s] = (op[s] == OP_READ);
        assign sel_way[s] = WAY_W'(int'(sel_idx[s]) / PARTS_PER_WAY);
        assign rd_way_flat[s*WAY_W +: WAY_W] = sel_way[s];

        always_comb begin : rd_gnt_map
            for (int p = 0; p < NP; p++)
                rd_gnt_slot[s][p] = req_gnt[p] && !req_we[p]
                                    && (int'(slot_flat[p*SLOT_W +: SLOT_W]) == s);
        end

        // R1
        slot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bank_en[s] |-> (hit_wr[s][sel_idx[s]] || hit_rd[s][sel_idx[s]]));
        // R2
        wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (|hit_wr[s]) |-> (bank_en[s] && bank_we[s]));
        // R7
        rd_gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(rd_gnt_slot[s]));
        // R8
        rsp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_en[s] && !bank_we[s]) |=>
                (rsp_vld[s] && rsp_way[s*WAY_W +: WAY_W] == $past(sel_way[s])));
    end

    always_comb begin : rd_first_merge
        rd_first_any = '0;
        for (int s = 0; s < NS; s++) rd_first_any = rd_first_any | rd_first[s];
    end

    sba_grant_gen #(.NP(NP), .PARTS_PER_WAY(PARTS_PER_WAY), .SLOT_W(SLOT_W)) u_gnt (
        .req_vld   (req_vld),
        .req_we    (req_we),
        .slot_flat (slot_flat),
        .rd_first  (rd_first_any),
        .req_gnt   (req_gnt)
    );

    sba_rsp_reg #(.NS(NS), .WAY_W(WAY_W)) u_rsp (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_fire     (rd_fire),
        .rd_way_flat (rd_way_flat),
        .rsp_vld     (rsp_vld),
        .rsp_way     (rsp_way)
    );

    assign rsp_data = bank_rdata;

    for (genvar p = 0; p < NP; p++) begin : g_part
        // R3
        wr_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_vld[p] && req_we[p]) |-> req_gnt[p]);
        // R4
        rd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_gnt[p] && !req_we[p]) |->
                !(bank_we[slot_flat[p*SLOT_W +: SLOT_W]]
                  && int'(sel_way[slot_flat[p*SLOT_W +: SLOT_W]]) != p / PARTS_PER_WAY));
    end

endmodule

// File: tb/tb_skew_bank_arb.sv
module tb_skew_bank_arb;

    localparam int NW = 4, PPW = 2, NC = 4, NB = 2, AW = 6, DW = 16;
    localparam int NP = NW * PPW, NS = NC * NB, CW = 2, BW = 1, WW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]    req_vld = '0, req_we = '0;
    logic [NP*CW-1:0] req_col = '0;
    logic [NP*BW-1:0] req_bank = '0;
    logic [NP*AW-1:0] req_addr = '0;
    logic [NP*DW-1:0] req_wdata = '0;
    logic [NP-1:0]    req_gnt;
    logic [NS-1:0]    bank_en, bank_we, rsp_vld;
    logic [NS*AW-1:0] bank_addr;
    logic [NS*DW-1:0] bank_wdata, rsp_data;
    logic [NS*DW-1:0] bank_rdata = '0;
    logic [NS*WW-1:0] rsp_way;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    logic [DW-1:0] mem [NS][64];

    typedef struct { int cyc; int slot; int way; logic [DW-1:0] data; } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    skew_bank_arb dut (.*);

    // Bank SRAM model: one-cycle read latency.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int s = 0; s < NS; s++)
                for (int a = 0; a < 64; a++) mem[s][a] <= DW'(s * 256 + a * 3 + 1);
        end else begin
            for (int s = 0; s < NS; s++) begin
                if (bank_en[s] && bank_we[s])
                    mem[s][bank_addr[s*AW +: AW]] <= bank_wdata[s*DW +: DW];
                if (bank_en[s] && !bank_we[s])
                    bank_rdata[s*DW +: DW] <= mem[s][bank_addr[s*AW +: AW]];
            end
        end
    end

    task automatic chk(bit ok, string rq, string what, longint act, longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
        end
    endtask

    task automatic clear_parts();
        req_vld = '0; req_we = '0; req_col = '0; req_bank = '0; req_addr = '0; req_wdata = '0;
    endtask

    task automatic set_part(int way, int part, bit we, int col, int bank, int addr, int data);
        int p;
        p = way * PPW + part;
        req_vld[p] = 1'b1;
        req_we[p] = we;
        req_col[p*CW +: CW] = CW'(col);
        req_bank[p*BW +: BW] = BW'(bank);
        req_addr[p*AW +: AW] = AW'(addr);
        req_wdata[p*DW +: DW] = DW'(data);
    endtask

    // Driver: model grants and bank outputs, queue expected responses.
    task automatic drive_and_check();
        int sl[NP];
        for (int p = 0; p < NP; p++)
            sl[p] = int'(req_col[p*CW +: CW]) * NB + int'(req_bank[p*BW +: BW]);   // R9
        #1;
        for (int p = 0; p < NP; p++) begin
            bit fw = 0, ow = 0, er = 0, e;
            string tg;
            for (int q = 0; q < NP; q++) begin
                if (q != p && req_vld[q] && sl[q] == sl[p]) begin
                    if (req_we[q]) begin
                        if (q / PPW != p / PPW) fw = 1; else ow = 1;
                    end else if (q < p) er = 1;
                end
            end
            e = req_vld[p] && (req_we[p] || (!fw && !er));
            tg = !req_vld[p] ? "R9" : req_we[p] ? "R3" : fw ? "R4" : er ? "R7" : ow ? "R5" : "R7";
            chk(req_gnt[p] == e, tg, $sformatf("gnt part %0d", p), req_gnt[p], e);
        end
        for (int s = 0; s < NS; s++) begin
            int wi = -1, ri = -1, nw = 0, w;
            for (int p = 0; p < NP; p++) begin
                if (req_vld[p] && sl[p] == s) begin
                    if (req_we[p]) begin nw++; if (wi < 0) wi = p; end
                    else if (ri < 0) ri = p;
                end
            end
            w = (wi >= 0) ? wi : ri;
            chk(bank_en[s] == (w >= 0), (w >= 0) ? "R1" : "R9",
                $sformatf("bank_en slot %0d", s), bank_en[s], w >= 0);
            if (w >= 0 && bank_en[s]) begin
                string tg;
                logic [AW+DW:0] act, expv;
                tg = (wi >= 0) ? ((nw > 1) ? "R6" : "R2") : "R7";
                act  = {bank_we[s], bank_addr[s*AW +: AW], bank_wdata[s*DW +: DW]};
                expv = {wi >= 0, req_addr[w*AW +: AW],
                        (wi >= 0) ? req_wdata[w*DW +: DW] : bank_wdata[s*DW +: DW]};
                chk(act == expv, tg, $sformatf("bank drive slot %0d", s), act, expv);
                if (wi < 0) exp_q.push_back('{cyc + 1, s, ri / PPW, mem[s][req_addr[ri*AW +: AW]]});
            end
        end
    endtask

    // Monitor: compares registered responses one cycle after the read.
    always @(negedge clk) begin : mon
        logic [NS-1:0] ev;
        int ew [NS];
        logic [DW-1:0] ed [NS];
        exp_t it;
        if (rst_n) begin
            ev = '0;
            while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
                it = exp_q.pop_front();
                chk(it.cyc == cyc, "R8", "response slot timing", cyc, it.cyc);
                ev[it.slot] = 1'b1;
                ew[it.slot] = it.way;
                ed[it.slot] = it.data;
            end
            for (int s = 0; s < NS; s++) begin
                chk(rsp_vld[s] == ev[s], "R8", $sformatf("rsp_vld slot %0d", s), rsp_vld[s], ev[s]);
                if (ev[s] && rsp_vld[s]) begin
                    chk(int'(rsp_way[s*WW +: WW]) == ew[s], "R8", $sformatf("rsp_way slot %0d", s),
                        rsp_way[s*WW +: WW], ew[s]);
                    chk(rsp_data[s*DW +: DW] == ed[s], "R8", $sformatf("rsp_data slot %0d", s),
                        rsp_data[s*DW +: DW], ed[s]);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(bank_en == '0, "R9", "reset bank_en", bank_en, 0);
        chk(rsp_vld == '0, "R8", "reset rsp_vld", rsp_vld, 0);
        chk(req_gnt == '0, "R3", "reset gnt", req_gnt, 0);
        rst_n = 1'b1;

        // R3 R9: single write to col1/bank1 = slot 3
        @(negedge clk); clear_parts();
        set_part(0, 0, 1, 1, 1, 5, 16'hBEEF);
        drive_and_check();
        // R8: read back through another way
        @(negedge clk); clear_parts();
        set_part(1, 0, 0, 1, 1, 5, 0);
        drive_and_check();
        // R2 R4: foreign write beats read on same slot
        @(negedge clk); clear_parts();
        set_part(2, 1, 1, 1, 1, 5, 16'h1234);
        set_part(1, 0, 0, 1, 1, 5, 0);
        drive_and_check();
        // R5: own-way write on same slot keeps read grant
        @(negedge clk); clear_parts();
        set_part(1, 0, 1, 2, 1, 2, 16'h5555);
        set_part(1, 1, 0, 2, 1, 2, 0);
        drive_and_check();
        // R6: two writers, lower index drives
        @(negedge clk); clear_parts();
        set_part(3, 0, 1, 0, 0, 7, 16'hAAAA);
        set_part(1, 1, 1, 0, 0, 9, 16'h7777);
        drive_and_check();
        // R7: two readers, lowest wins
        @(negedge clk); clear_parts();
        set_part(3, 1, 0, 3, 0, 1, 0);
        set_part(0, 1, 0, 3, 0, 4, 0);
        drive_and_check();
        // R8: responses on two slots in one cycle
        @(negedge clk); clear_parts();
        set_part(2, 0, 0, 0, 1, 3, 0);
        set_part(3, 1, 0, 3, 1, 8, 0);
        drive_and_check();
        @(negedge clk); clear_parts();
        drive_and_check();

        // Mixed traffic on few slots to force collisions
        for (int n = 0; n < 400; n++) begin
            @(negedge clk); clear_parts();
            for (int w = 0; w < NW; w++)
                for (int k = 0; k < PPW; k++)
                    if ($urandom % 3 != 0)
                        set_part(w, k, ($urandom % 4) == 0, $urandom % 2, $urandom % 2,
                                 $urandom % 8, $urandom);
            drive_and_check();
        end
        @(negedge clk); clear_parts();
        drive_and_check();
        repeat (2) @(negedge clk);
        #1;
        chk(exp_q.size() == 0, "R8", "pending responses", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule